// File: doc/BRIEF.md
# Thermal and Undervoltage Fault Supervisor

This block sits beside an H-bridge controller and decides two things every clock: whether the bridge must be forced off, and whether the active-low diagnostic flag should be pulled low. It takes an unsigned die-temperature code in degrees Celsius, a supply-undervoltage comparator output, a charge-pump-undervoltage comparator output, a motor-fault indication from the overcurrent logic and the sleep request.

Temperature is handled in two tiers. The lower tier is a warning that only pulls the flag low. The upper tier is a shutdown that turns the bridge off. Each tier has its own hysteresis. After reset the bridge is held off until the supply has been seen valid for a run of consecutive cycles. Any supply dip restarts that run. The flag reports conditions only and never changes bridge behaviour. During sleep the flag is released (driven high). All inputs are registered once, so every output reacts one clock after the input that causes it.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is held, and right after it, `bridge_off` is 1 and `fault_n` is 0.
- R2: With `temp_code` >= WARN_TRIP (default 160), `fault_n` is 0 one cycle later (outside sleep). This warning alone leaves `bridge_off` at 0.
- R3: Once raised, the warning stays active while `temp_code` > WARN_TRIP - HYST (default 145). It clears one cycle after `temp_code` <= 145. A code of 159 on a cool die does not raise it.
- R4: With `temp_code` >= SHUT_TRIP (default 175), `bridge_off` is 1 one cycle later.
- R5: Once shut down, `bridge_off` stays 1 while `temp_code` > SHUT_TRIP - HYST (default 160). It returns to 0 one cycle after `temp_code` <= 160, provided no other cause holds it.
- R6: With `vcp_low` = 1, `bridge_off` is 1 and `fault_n` is 0 (outside sleep) one cycle later. Both release one cycle after `vcp_low` returns to 0.
- R7: `bridge_off` and a low `fault_n` are held until `vsup_low` has been 0 for QUAL_CYCLES (default 4) consecutive clock edges. A single edge with `vsup_low` = 1 re-locks and restarts the count.
- R8: With `motor_fault` = 1, `fault_n` is 0 one cycle later (outside sleep). `bridge_off` is not affected.
- R9: With `sleep_req` = 1, `fault_n` is 1 one cycle later, whatever the fault sources are. `bridge_off` still follows the shutdown and undervoltage causes.

Inputs are sampled at the rising edge. `bridge_off` and `fault_n` are the only outputs, and both are driven from the sampled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | 1 = low-power mode; releases the flag |
| temp_code | input | TEMP_W (8) | Die temperature, unsigned degrees Celsius |
| vsup_low | input | 1 | 1 = supply below its undervoltage threshold |
| vcp_low | input | 1 | 1 = charge-pump rail below its threshold |
| motor_fault | input | 1 | 1 = overcurrent logic reports a motor fault |
| bridge_off | output | 1 | 1 = bridge outputs must be disabled |
| fault_n | output | 1 | Active-low diagnostic flag, 0 = fault |

## Verification
The hardest situations to reach are the hysteresis bands. To test them the temperature must first be driven past a trip and then walked back into the band, so the held state can be told apart from a fresh comparison. The stimulus climbs to 175, then steps through 174, 161 and exactly 160. At 160 the shutdown must release while the warning still holds the flag low. The power-up qualifier is reached in a similar way. A one-edge supply dip is placed after a valid run, and the bench counts out the four edges needed to release again.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Sources of a diagnostic flag, all sampled state
  typedef struct packed {
    logic warn;
    logic shut;
    logic cp_uv;
    logic pwr_bad;
    logic motor;
  } fault_src_t;

  // Release point of a hysteresis tier, clamped at zero
  function automatic int unsigned release_pt(input int unsigned trip, input int unsigned hyst);
    return (trip > hyst) ? (trip - hyst) : 0;
  endfunction

  // Next state of a tier: set at >= trip, hold while above the release point
  function automatic logic hyst_next(input logic active, input int unsigned t,
                                     input int unsigned trip, input int unsigned hyst);
    if (active) return (t > release_pt(trip, hyst));
    return (t >= trip);
  endfunction

endpackage

// File: rtl/sup_hyst_cmp.sv
module sup_hyst_cmp #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned TRIP   = 160,
  parameter int unsigned HYST   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp,
  output logic              active
);
  import fsup_pkg::*;

  logic [31:0] temp_ext;
  assign temp_ext = 32'(temp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= hyst_next(active, temp_ext, TRIP, HYST);
  end
endmodule

// File: rtl/sup_uv_qual.sv
module sup_uv_qual #(
  parameter int unsigned QUAL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  output logic supply_ok
);
  localparam int unsigned CW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      supply_ok <= 1'b0;
    end else if (supply_low) begin
      run_cnt   <= '0;
      supply_ok <= 1'b0;
    end else if (!supply_ok) begin
      if (run_cnt == LAST) supply_ok <= 1'b1;
      else                 run_cnt   <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_flag_merge.sv
module sup_flag_merge (
  input  fsup_pkg::fault_src_t src,
  input  logic                 asleep,
  output logic                 off_req,
  output logic                 flag_n
);
  always_comb begin
    // Only shutdown-class causes gate the bridge
    off_req = src.shut | src.cp_uv | src.pwr_bad;
    // The flag reports every cause but is released in sleep
    if (asleep) flag_n = 1'b1;
    else        flag_n = ~(src.warn | src.shut | src.cp_uv | src.pwr_bad | src.motor);
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned WARN_TRIP   = 160,
  parameter int unsigned SHUT_TRIP   = 175,
  parameter int unsigned HYST        = 15,
  parameter int unsigned QUAL_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              vsup_low,
  input  logic              vcp_low,
  input  logic              motor_fault,
  output logic              bridge_off,
  output logic              fault_n
);
  import fsup_pkg::*;

  localparam int unsigned NTIER = 2;

  // Named internal events, visible to the checker
  logic [NTIER-1:0] tier_hot;
  logic warn_st, shut_st, pwr_ok, cp_uv_st, motor_st, sleep_st;
  fault_src_t src;

  genvar gi;
  generate
    for (gi = 0; gi < NTIER; gi++) begin : g_tier
      sup_hyst_cmp #(
        .TEMP_W(TEMP_W),
        .TRIP  ((gi == 0) ? WARN_TRIP : SHUT_TRIP),
        .HYST  (HYST)
      ) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .temp  (temp_code),
        .active(tier_hot[gi])
      );
    end
  endgenerate

  assign warn_st = tier_hot[0];
  assign shut_st = tier_hot[1];

  sup_uv_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_low(vsup_low),
    .supply_ok (pwr_ok)
  );

  // One sampling stage for the single-bit inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_uv_st <= 1'b1;
      motor_st <= 1'b0;
      sleep_st <= 1'b0;
    end else begin
      cp_uv_st <= vcp_low;
      motor_st <= motor_fault;
      sleep_st <= sleep_req;
    end
  end

  always_comb begin
    src.warn    = warn_st;
    src.shut    = shut_st;
    src.cp_uv   = cp_uv_st;
    src.pwr_bad = ~pwr_ok;
    src.motor   = motor_st;
  end

  sup_flag_merge u_merge (
    .src    (src),
    .asleep (sleep_st),
    .off_req(bridge_off),
    .flag_n (fault_n)
  );
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
  parameter int unsigned TEMP_W    = 8,
  parameter int unsigned WARN_TRIP = 160,
  parameter int unsigned SHUT_TRIP = 175,
  parameter int unsigned HYST      = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic [TEMP_W-1:0] temp_code,
  input logic              vsup_low,
  input logic              vcp_low,
  input logic              motor_fault,
  input logic              bridge_off,
  input logic              fault_n,
  input logic              shut_st
);
  logic [31:0] t32;
  assign t32 = 32'(temp_code);

  // R2
  warn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t32 >= WARN_TRIP && !sleep_req) |=> !fault_n);

  // R4
  shut_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t32 >= SHUT_TRIP) |=> bridge_off);

  // R5
  shut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_st && t32 > SHUT_TRIP - HYST) |=> shut_st);

  // R6
  cp_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcp_low |=> bridge_off);

  // R7
  supply_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsup_low |=> bridge_off);

  // R8
  motor_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_fault && !sleep_req) |=> !fault_n);

  // R9
  sleep_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> fault_n);
endmodule

bind fault_supervisor fault_supervisor_chk #(
  .TEMP_W(TEMP_W), .WARN_TRIP(WARN_TRIP), .SHUT_TRIP(SHUT_TRIP), .HYST(HYST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .temp_code(temp_code),
  .vsup_low(vsup_low), .vcp_low(vcp_low), .motor_fault(motor_fault),
  .bridge_off(bridge_off), .fault_n(fault_n), .shut_st(shut_st)
);

// File: tb/fault_supervisor_tb.sv
`timescale 1ns/1ps
module fault_supervisor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic       vsup_low = 1'b1;
  logic       vcp_low = 1'b0;
  logic       motor_fault = 1'b0;
  logic       bridge_off, fault_n;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  fault_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .temp_code(temp_code),
    .vsup_low(vsup_low), .vcp_low(vcp_low), .motor_fault(motor_fault),
    .bridge_off(bridge_off), .fault_n(fault_n)
  );

  // Driver: one cycle of stimulus plus its expected outputs
  task automatic drive(input logic slp, input int t, input logic vs, input logic vc,
                       input logic mf, input logic e_off, input logic e_fn, input string tag);
    @(negedge clk);
    sleep_req   = slp;
    temp_code   = 8'(t);
    vsup_low    = vs;
    vcp_low     = vc;
    motor_fault = mf;
    exp_q.push_back({e_off, e_fn});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if ({bridge_off, fault_n} !== e) begin
          errors++;
          $display("FAIL %s: off/flag actual %b%b expected %b%b", tg, bridge_off, fault_n, e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (bridge_off !== 1'b1 || fault_n !== 1'b0) begin
      errors++;
      $display("FAIL R1: off/flag actual %b%b expected 10", bridge_off, fault_n);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1 right after reset, R7 qualification run of four edges
    drive(0, 25, 0, 0, 0, 1, 0, "R1");
    drive(0, 25, 0, 0, 0, 1, 0, "R7");
    drive(0, 25, 0, 0, 0, 1, 0, "R7");
    drive(0, 25, 0, 0, 0, 0, 1, "R7");
    // R7 single-edge dip re-locks
    drive(0, 25, 1, 0, 0, 1, 0, "R7");
    drive(0, 25, 0, 0, 0, 1, 0, "R7");
    drive(0, 25, 0, 0, 0, 1, 0, "R7");
    drive(0, 25, 0, 0, 0, 1, 0, "R7");
    drive(0, 25, 0, 0, 0, 0, 1, "R7");
    // R2/R3 warning tier
    drive(0, 159, 0, 0, 0, 0, 1, "R3");
    drive(0, 160, 0, 0, 0, 0, 0, "R2");
    drive(0, 159, 0, 0, 0, 0, 0, "R3");
    drive(0, 146, 0, 0, 0, 0, 0, "R3");
    drive(0, 145, 0, 0, 0, 0, 1, "R3");
    drive(0, 159, 0, 0, 0, 0, 1, "R3");
    // R4/R5 shutdown tier
    drive(0, 174, 0, 0, 0, 0, 0, "R4");
    drive(0, 175, 0, 0, 0, 1, 0, "R4");
    drive(0, 174, 0, 0, 0, 1, 0, "R5");
    drive(0, 161, 0, 0, 0, 1, 0, "R5");
    drive(0, 160, 0, 0, 0, 0, 0, "R5");
    drive(0, 200, 0, 0, 0, 1, 0, "R4");
    drive(0, 25, 0, 0, 0, 0, 1, "R5");
    // R6 charge pump
    drive(0, 25, 0, 1, 0, 1, 0, "R6");
    drive(0, 25, 0, 0, 0, 0, 1, "R6");
    // R8 motor fault
    drive(0, 25, 0, 0, 1, 0, 0, "R8");
    drive(0, 25, 0, 0, 0, 0, 1, "R8");
    // R9 sleep
    drive(1, 25, 0, 0, 1, 0, 1, "R9");
    drive(1, 180, 0, 0, 0, 1, 1, "R9");
    drive(1, 180, 0, 1, 0, 1, 1, "R9");
    drive(0, 180, 0, 0, 0, 1, 0, "R9");
    drive(0, 25, 0, 0, 0, 0, 1, "R9");
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule